// File: doc/BRIEF.md
# Operand Effective-Address Decoder

This block turns the operand-addressing bytes of a two-operand instruction into what the execute stage needs. It splits the addressing byte into its fields and reports whether the second operand is a register or memory. For memory operands it forms the effective address from the current general-register values and an already sign-extended displacement. It also gives the default segment class and tells the fetch logic whether a scale/index/base byte and which size of displacement the encoding consumes.

Two address-size modes are supported, selected per request. The 16-bit mode sums fixed register pairs and wraps at 64 KiB. The 32-bit mode uses any single base register, can escape to a scale/index/base byte and has a displacement-only form. An optional output register, on by default, sits behind the combinational decode.

Top module: `modrm_addr_decoder`

## Requirements
- R1: The addressing byte is split as mode = bits 7:6, reg field = bits 5:3 and r/m field = bits 2:0. `reg_idx_o` always carries the reg field and `rm_idx_o` always carries the r/m field. Register indices 0..7 are AX, CX, DX, BX, SP, BP, SI, DI.
- R2: With mode 11, `rm_is_reg_o` is 1, `ea_o` is 0, `seg_ss_o` is 0, `sib_needed_o` is 0 and `disp_kind_o` is 0. With any other mode, `rm_is_reg_o` is 0.
- R3: `disp_kind_o` encodes 0 = no displacement, 1 = 8-bit, 2 = full width. Mode 01 gives 1 and mode 10 gives 2, and in both the address includes `disp_i`. Mode 00 gives 0 except in the direct forms of R7, R6 and R8.
- R4: In 32-bit mode (`addr32_i`=1), r/m 100 with a mode other than 11 sets `sib_needed_o`. The address is then base + (index << scale) + displacement, where the scale/index/base byte has scale = bits 7:6, index = bits 5:3 and base = bits 2:0.
- R5: An index code of 100 adds no index term.
- R6: Base code 101 with mode 00 drops the base register and uses `disp_i` with `disp_kind_o`=2. With mode 01 or 10, base code 101 selects BP.
- R7: In 32-bit mode, mode 00 with r/m 101 gives `ea_o` = `disp_i`, with `disp_kind_o`=2, `seg_ss_o`=0 and no scale/index/base byte.
- R8: In 16-bit mode, r/m 0..7 address BX+SI, BX+DI, BP+SI, BP+DI, SI, DI, BP and BX, using the low 16 bits of each register and of `disp_i`. Mode 00 with r/m 110 is instead the direct 16-bit displacement, with `disp_kind_o`=2.
- R9: `seg_ss_o`=1 (stack segment) applies to the BP-based 16-bit forms and to a 32-bit base of SP or BP. The displacement-only forms give 0 (data segment).
- R10: 16-bit addresses wrap modulo 2^16 and have bits 31:16 at zero. 32-bit addresses wrap modulo 2^32.
- R11: With `OUT_REG`=1, results and `valid_o` appear one clock after `valid_i`. `valid_o` is 0 in the cycle after an idle input. Reset drives `valid_o` and every result output to 0.
- R12: In 16-bit mode, `sib_needed_o` is always 0, even for r/m 100.
- R13: Mode 01 with r/m 100 and scale/index/base byte 8Bh decodes to BX + CX*4 + disp8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request valid |
| modrm_i | input | 8 | Addressing byte |
| sib_i | input | 8 | Scale/index/base byte (used only when needed) |
| disp_i | input | 32 | Sign-extended displacement |
| addr32_i | input | 1 | 1 = 32-bit addressing, 0 = 16-bit |
| gpr_i | input | 256 | Eight 32-bit registers; register n at bits n*32+31:n*32 |
| valid_o | output | 1 | Result valid |
| rm_is_reg_o | output | 1 | Second operand is a register |
| rm_idx_o | output | 3 | r/m field |
| reg_idx_o | output | 3 | reg field |
| ea_o | output | 32 | Effective address |
| seg_ss_o | output | 1 | Default segment is the stack segment |
| sib_needed_o | output | 1 | Scale/index/base byte consumed |
| disp_kind_o | output | 2 | Displacement size consumed |

## Verification
The bench targets the escape paths:
- **r/m 100 in both modes.** A decoder that ignored the mode would request a scale/index/base byte for a 16-bit SI access.
- **Base code 101 with mode 00 versus 01.** Getting this wrong adds BP where there is none, or loses it.
- **The 16-bit direct form.** A design that missed this case would read BP and pick the stack segment.
- **Scale 8 with an index of 100, and sums that cross 2^16 and 2^32.** Mistakes here show as a wrong scaled index, a spurious index term, or high address bits leaking into 16-bit results.

Register values are chosen so that every register contributes a distinct pattern. A wrong register selection is therefore always visible in `ea_o`.

// File: rtl/modrm_dec_pkg.sv
package modrm_dec_pkg;
  localparam int REG_W   = 32;
  localparam int NUM_GPR = 8;
  localparam int IDX_W   = $clog2(NUM_GPR);
  localparam int A16_W   = 16;

  localparam logic [IDX_W-1:0] GPR_BX = 3'd3;
  localparam logic [IDX_W-1:0] GPR_SP = 3'd4;
  localparam logic [IDX_W-1:0] GPR_BP = 3'd5;
  localparam logic [IDX_W-1:0] GPR_SI = 3'd6;
  localparam logic [IDX_W-1:0] GPR_DI = 3'd7;

  typedef logic [NUM_GPR-1:0][REG_W-1:0] gpr_file_t;

  typedef enum logic [1:0] {
    DISP_NONE  = 2'd0,
    DISP_SHORT = 2'd1,
    DISP_FULL  = 2'd2
  } disp_kind_e;

  typedef struct packed {
    logic             rm_is_reg;
    logic [IDX_W-1:0] rm_idx;
    logic [IDX_W-1:0] reg_idx;
    logic [REG_W-1:0] ea;
    logic             seg_ss;
    logic             sib_needed;
    disp_kind_e       disp_kind;
  } dec_res_t;
endpackage

// File: rtl/ea16_unit.sv
module ea16_unit
  import modrm_dec_pkg::*;
(
  input  logic [1:0]       mod_i,
  input  logic [IDX_W-1:0] rm_i,
  input  logic [A16_W-1:0] disp_i,
  input  logic [A16_W-1:0] bx_i,
  input  logic [A16_W-1:0] bp_i,
  input  logic [A16_W-1:0] si_i,
  input  logic [A16_W-1:0] di_i,
  output logic [A16_W-1:0] ea_o,
  output logic             seg_ss_o,
  output disp_kind_e       disp_kind_o
);
  logic             direct;
  logic [A16_W-1:0] base_sum;
  logic [A16_W-1:0] disp_add;

  assign direct = (mod_i == 2'b00) && (rm_i == 3'd6);

  always_comb begin
    unique case (rm_i)
      3'd0: base_sum = bx_i + si_i;
      3'd1: base_sum = bx_i + di_i;
      3'd2: base_sum = bp_i + si_i;
      3'd3: base_sum = bp_i + di_i;
      3'd4: base_sum = si_i;
      3'd5: base_sum = di_i;
      3'd6: base_sum = bp_i;
      default: base_sum = bx_i;
    endcase
  end

  always_comb begin
    disp_add    = '0;
    disp_kind_o = DISP_NONE;
    unique case (mod_i)
      2'b01: begin disp_add = disp_i; disp_kind_o = DISP_SHORT; end
      2'b10: begin disp_add = disp_i; disp_kind_o = DISP_FULL;  end
      2'b00: if (direct) disp_kind_o = DISP_FULL;
      default: ;
    endcase
  end

  always_comb begin
    if (mod_i == 2'b11)  ea_o = '0;
    else if (direct)     ea_o = disp_i;
    else                 ea_o = base_sum + disp_add;
  end

  // stack segment for BP-based pairs and BP alone (not the direct form)
  assign seg_ss_o = (mod_i != 2'b11) && !direct &&
                    ((rm_i == 3'd2) || (rm_i == 3'd3) || (rm_i == 3'd6));
endmodule

// File: rtl/ea32_unit.sv
module ea32_unit
  import modrm_dec_pkg::*;
(
  input  logic [1:0]       mod_i,
  input  logic [IDX_W-1:0] rm_i,
  input  logic [7:0]       sib_i,
  input  logic [REG_W-1:0] disp_i,
  input  gpr_file_t        gpr_i,
  output logic [REG_W-1:0] ea_o,
  output logic             seg_ss_o,
  output logic             sib_needed_o,
  output disp_kind_e       disp_kind_o
);
  logic [1:0]       scale;
  logic [IDX_W-1:0] idx_code, base_code;
  logic             mem_form, no_base, disp_only;
  logic [REG_W-1:0] base_val, index_val, disp_add;
  logic [IDX_W-1:0] base_sel;

  assign scale     = sib_i[7:6];
  assign idx_code  = sib_i[5:3];
  assign base_code = sib_i[2:0];

  assign mem_form     = (mod_i != 2'b11);
  assign sib_needed_o = mem_form && (rm_i == GPR_SP);
  // base register that would be used, before the no-base escapes
  assign base_sel     = sib_needed_o ? base_code : rm_i;
  assign no_base      = (mod_i == 2'b00) && (base_sel == GPR_BP);
  assign disp_only    = no_base && !sib_needed_o;

  assign base_val  = no_base ? '0 : gpr_i[base_sel];
  assign index_val = (sib_needed_o && (idx_code != GPR_SP)) ?
                     (gpr_i[idx_code] << scale) : '0;

  always_comb begin
    disp_add    = '0;
    disp_kind_o = DISP_NONE;
    unique case (mod_i)
      2'b01: begin disp_add = disp_i; disp_kind_o = DISP_SHORT; end
      2'b10: begin disp_add = disp_i; disp_kind_o = DISP_FULL;  end
      2'b00: if (no_base) begin disp_add = disp_i; disp_kind_o = DISP_FULL; end
      default: ;
    endcase
  end

  assign ea_o     = mem_form ? (base_val + index_val + disp_add) : '0;
  assign seg_ss_o = mem_form && !no_base && !disp_only &&
                    ((base_sel == GPR_SP) || (base_sel == GPR_BP));
endmodule

// File: rtl/dec_out_stage.sv
module dec_out_stage
  import modrm_dec_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     valid_i,
  input  dec_res_t res_i,
  output logic     valid_o,
  output dec_res_t res_o
);
  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_o <= 1'b0;
        res_o   <= '0;
      end else begin
        valid_o <= valid_i;
        res_o   <= valid_i ? res_i : '0;
      end
    end

    assert_latency_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i |=> valid_o && (res_o == $past(res_i)));
    assert_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !valid_i |=> !valid_o);
  end else begin : g_comb
    assign valid_o = valid_i;
    assign res_o   = res_i;
  end
endmodule

// File: rtl/modrm_addr_decoder.sv
module modrm_addr_decoder
  import modrm_dec_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic [7:0]               modrm_i,
  input  logic [7:0]               sib_i,
  input  logic [REG_W-1:0]         disp_i,
  input  logic                     addr32_i,
  input  logic [NUM_GPR*REG_W-1:0] gpr_i,
  output logic                     valid_o,
  output logic                     rm_is_reg_o,
  output logic [IDX_W-1:0]         rm_idx_o,
  output logic [IDX_W-1:0]         reg_idx_o,
  output logic [REG_W-1:0]         ea_o,
  output logic                     seg_ss_o,
  output logic                     sib_needed_o,
  output logic [1:0]               disp_kind_o
);
  logic [1:0]       mod_f;
  logic [IDX_W-1:0] reg_f, rm_f;
  gpr_file_t        gprs;

  logic [A16_W-1:0] ea16;
  logic             ss16;
  disp_kind_e       dk16;
  logic [REG_W-1:0] ea32;
  logic             ss32, sib32;
  disp_kind_e       dk32;

  dec_res_t res_c, res_q;

  assign mod_f = modrm_i[7:6];
  assign reg_f = modrm_i[5:3];
  assign rm_f  = modrm_i[2:0];
  assign gprs  = gpr_i;

  ea16_unit i_ea16 (
    .mod_i       (mod_f),
    .rm_i        (rm_f),
    .disp_i      (disp_i[A16_W-1:0]),
    .bx_i        (gprs[GPR_BX][A16_W-1:0]),
    .bp_i        (gprs[GPR_BP][A16_W-1:0]),
    .si_i        (gprs[GPR_SI][A16_W-1:0]),
    .di_i        (gprs[GPR_DI][A16_W-1:0]),
    .ea_o        (ea16),
    .seg_ss_o    (ss16),
    .disp_kind_o (dk16)
  );

  ea32_unit i_ea32 (
    .mod_i        (mod_f),
    .rm_i         (rm_f),
    .sib_i        (sib_i),
    .disp_i       (disp_i),
    .gpr_i        (gprs),
    .ea_o         (ea32),
    .seg_ss_o     (ss32),
    .sib_needed_o (sib32),
    .disp_kind_o  (dk32)
  );

  always_comb begin
    res_c.rm_is_reg  = (mod_f == 2'b11);
    res_c.rm_idx     = rm_f;
    res_c.reg_idx    = reg_f;
    res_c.ea         = addr32_i ? ea32 : {{(REG_W-A16_W){1'b0}}, ea16};
    res_c.seg_ss     = addr32_i ? ss32 : ss16;
    res_c.sib_needed = addr32_i && sib32;
    res_c.disp_kind  = addr32_i ? dk32 : dk16;
  end

  dec_out_stage #(.OUT_REG(OUT_REG)) i_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .res_i   (res_c),
    .valid_o (valid_o),
    .res_o   (res_q)
  );

  assign rm_is_reg_o  = res_q.rm_is_reg;
  assign rm_idx_o     = res_q.rm_idx;
  assign reg_idx_o    = res_q.reg_idx;
  assign ea_o         = res_q.ea;
  assign seg_ss_o     = res_q.seg_ss;
  assign sib_needed_o = res_q.sib_needed;
  assign disp_kind_o  = res_q.disp_kind;

  assert_reg_form_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (mod_f == 2'b11) |-> (dk32 == DISP_NONE) && (dk16 == DISP_NONE) && !sib32);
  assert_short_disp_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (mod_f == 2'b01) |-> (res_c.disp_kind == DISP_SHORT));
  assert_sib_escape_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && addr32_i && (mod_f != 2'b11) && (rm_f == 3'd4) |-> sib32);
  assert_direct_ds_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (mod_f == 2'b00) &&
    ((addr32_i && rm_f == 3'd5) || (!addr32_i && rm_f == 3'd6))
    |-> !res_c.seg_ss && (res_c.disp_kind == DISP_FULL));
  assert_no_sib16_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !addr32_i |-> !res_c.sib_needed && (res_c.ea[REG_W-1:A16_W] == '0));
endmodule

// File: tb/test_modrm_addr_decoder.sv
module test_modrm_addr_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [7:0]  modrm_i = '0, sib_i = '0;
  logic [31:0] disp_i = '0;
  logic        addr32_i = 1'b0;
  logic [255:0] gpr_flat;
  logic        valid_o, rm_is_reg_o, seg_ss_o, sib_needed_o;
  logic [2:0]  rm_idx_o, reg_idx_o;
  logic [31:0] ea_o;
  logic [1:0]  disp_kind_o;

  int checks = 0, fails = 0;

  logic [31:0] gv [8];

  typedef struct {
    logic [42:0] exp;
    string       tag;
  } item_t;
  item_t sb_q[$];

  always #2 clk = ~clk; // 250 MHz

  modrm_addr_decoder i_modrm_addr_decoder (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .modrm_i(modrm_i),
    .sib_i(sib_i), .disp_i(disp_i), .addr32_i(addr32_i), .gpr_i(gpr_flat),
    .valid_o(valid_o), .rm_is_reg_o(rm_is_reg_o), .rm_idx_o(rm_idx_o),
    .reg_idx_o(reg_idx_o), .ea_o(ea_o), .seg_ss_o(seg_ss_o),
    .sib_needed_o(sib_needed_o), .disp_kind_o(disp_kind_o)
  );

  initial begin
    gv[0] = 32'h0000_1110; gv[1] = 32'h0000_2220; gv[2] = 32'h0003_3330;
    gv[3] = 32'h0000_8004; gv[4] = 32'h7fff_fff0; gv[5] = 32'hffff_ff00;
    gv[6] = 32'h0000_f00d; gv[7] = 32'h1234_5678;
  end
  always_comb for (int i = 0; i < 8; i++) gpr_flat[i*32 +: 32] = gv[i];

  function automatic logic [42:0] model(logic [7:0] m, logic [7:0] s,
                                        logic [31:0] d, bit a32);
    logic [1:0] md = m[7:6];
    logic [2:0] r = m[2:0];
    logic [31:0] ea = '0;
    logic ss = 0, sb = 0;
    logic [1:0] dk = 0;
    logic [15:0] a16;
    if (md != 2'b11) begin
      dk = (md == 2'b01) ? 2'd1 : (md == 2'b10) ? 2'd2 : 2'd0;
      if (!a32) begin
        case (r)
          0: a16 = gv[3][15:0] + gv[6][15:0];
          1: a16 = gv[3][15:0] + gv[7][15:0];
          2: a16 = gv[5][15:0] + gv[6][15:0];
          3: a16 = gv[5][15:0] + gv[7][15:0];
          4: a16 = gv[6][15:0];
          5: a16 = gv[7][15:0];
          6: a16 = gv[5][15:0];
          default: a16 = gv[3][15:0];
        endcase
        ss = (r == 2 || r == 3 || r == 6);
        if (md == 0 && r == 6) begin a16 = d[15:0]; ss = 0; dk = 2; end
        else if (md != 0) a16 = a16 + d[15:0];
        ea = {16'h0, a16};
      end else if (r == 4) begin
        logic [2:0] b = s[2:0], x = s[5:3];
        sb = 1;
        if (b == 5 && md == 0) begin ea = d; dk = 2; end
        else begin ea = gv[b] + ((md != 0) ? d : 32'h0); ss = (b == 4 || b == 5); end
        if (x != 4) ea = ea + gv[x] * (32'd1 << s[7:6]);
      end else if (md == 0 && r == 5) begin
        ea = d; dk = 2;
      end else begin
        ea = gv[r] + ((md != 0) ? d : 32'h0);
        ss = (r == 5);
      end
    end
    return {md == 2'b11, r, m[5:3], ea, ss, sb, dk};
  endfunction

  task automatic send(logic [7:0] m, logic [7:0] s, logic [31:0] d, bit a32,
                      string tag);
    item_t it;
    @(negedge clk);
    modrm_i = m; sib_i = s; disp_i = d; addr32_i = a32; valid_i = 1'b1;
    it.exp = model(m, s, d, a32);
    it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic idle();
    @(negedge clk);
    valid_i = 1'b0;
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && valid_o) begin
      logic [42:0] act;
      item_t it;
      act = {rm_is_reg_o, rm_idx_o, reg_idx_o, ea_o, seg_ss_o, sib_needed_o, disp_kind_o};
      checks++;
      if (sb_q.size() == 0) begin
        fails++;
        $display("FAIL R11 unexpected result act=%h exp=none", act);
      end else begin
        it = sb_q.pop_front();
        if (act !== it.exp) begin
          fails++;
          $display("FAIL %s act=%h exp=%h", it.tag, act, it.exp);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++; // R11 reset state
    if (valid_o !== 1'b0 || ea_o !== '0 || disp_kind_o !== '0 || rm_idx_o !== '0) begin
      fails++;
      $display("FAIL R11 reset act=%b/%h exp=0/0", valid_o, ea_o);
    end
    rst_n = 1'b1;
    // register forms
    send(8'hD1, 8'h00, 32'h0, 1, "R1 R2 reg form 32");
    send(8'hFF, 8'h00, 32'h0, 0, "R2 reg form 16");
    // 16-bit table
    send(8'h00, 8'h00, 32'h0, 0, "R8 bx+si");
    send(8'h41, 8'h00, 32'hffff_fffc, 0, "R8 R3 bx+di+d8");
    send(8'h82, 8'h00, 32'h0000_1234, 0, "R8 R9 bp+si+d16");
    send(8'h03, 8'h00, 32'h0, 0, "R8 R9 bp+di");
    send(8'h44, 8'h77, 32'h0000_0008, 0, "R12 si+d8 no sib");
    send(8'h05, 8'h00, 32'h0, 0, "R8 di");
    send(8'h46, 8'h00, 32'h0000_0010, 0, "R9 bp+d8");
    send(8'h06, 8'h00, 32'hffff_beef, 0, "R8 R9 direct d16");
    send(8'h0F, 8'h00, 32'h0, 0, "R1 bx reg1");
    send(8'h86, 8'h00, 32'h0000_0200, 0, "R10 wrap16");
    idle();
    @(negedge clk);
    checks++;
    if (valid_o !== 1'b0) begin
      fails++;
      $display("FAIL R11 idle act=%b exp=0", valid_o);
    end
    // 32-bit
    send(8'h03, 8'h00, 32'h0, 1, "R1 [ebx]");
    send(8'h45, 8'h00, 32'h0000_0008, 1, "R9 R3 ebp+d8");
    send(8'h05, 8'h00, 32'hdead_0000, 1, "R7 disp only");
    send(8'h81, 8'h00, 32'h8000_0000, 1, "R3 ecx+d32");
    send(8'h54, 8'h8B, 32'h0000_0015, 1, "R13 R4 sib 8B");
    send(8'h04, 8'h25, 32'h0001_0000, 1, "R5 R6 sib no base no index");
    send(8'h44, 8'h25, 32'h0000_0004, 1, "R6 sib ebp base");
    send(8'h04, 8'h24, 32'h0, 1, "R9 R5 sib esp base");
    send(8'h84, 8'hFE, 32'hf000_0000, 1, "R4 R10 scale8 wrap32");
    send(8'h04, 8'h4A, 32'h0, 1, "R4 edx+ecx*2");
    idle();
    repeat (3) @(negedge clk);
    checks++;
    if (sb_q.size() != 0) begin
      fails++;
      $display("FAIL R11 pending act=%0d exp=0", sb_q.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule